// File: doc/BRIEF.md
# Oversampled Lane Transition Histogram

This block builds an edge-position histogram for one serial data lane that is sampled at ten times its interface clock. Because the lane is double data rate, its data may change on either clock edge, so two edge slots fall inside each window of ten samples. A window of ten consecutive samples arrives in parallel with a strobe. The block compares adjacent samples and counts, per boundary between neighbouring sampling positions, how often the lane changed value there. Software reads the ten counters and looks for where transitions cluster (the eye edges) and where they are rare (the eye centre).

The boundary set is offset and wraps into the following window. The latest window is held in a register, and every comparison is made when the next window arrives, so all ten counters update together in that cycle. Counting can be paused without losing the held window. A synchronous clear zeroes the counters and drops the held window. One counter at a time is read through an address/data port with one cycle of latency.

Top module: `lane_edge_hist`

## Requirements
- R1: Bit n of `win_i` is the sample at position n (0..9). When a counting update happens, counter k for k = 0..6 increments if positions k+2 and k+3 of the held (older) window differ.
- R2: On a counting update, counter 7 increments if position 9 of the held window differs from position 0 of the arriving window.
- R3: On a counting update, counter 9 increments if positions 0 and 1 of the arriving window differ, and counter 8 increments if positions 1 and 2 of the arriving window differ.
- R4: A counting update happens only in a cycle where `win_valid_i` is high and a window is already held. The first window after reset or clear is only stored, and no counter changes.
- R5: While `count_en_i` is low, no counter changes. Arriving windows are still stored, so the next enabled window is compared against the latest one.
- R6: Each counter is 16 bits wide and stops at 65535 instead of wrapping.
- R7: `clear_i` zeroes all counters and discards the held window in one cycle. It takes priority over a window arriving in the same cycle.
- R8: `rd_data_o` shows the counter selected by `rd_addr_i` one cycle after the address is presented. Addresses 10 to 15 read as zero.
- R9: After reset all counters read zero and no window is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling-window clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_i | input | 10 | Sample window, bit n = position n |
| win_valid_i | input | 1 | Window strobe |
| count_en_i | input | 1 | Counting enable |
| clear_i | input | 1 | Synchronous clear of counters and held window |
| rd_addr_i | input | 4 | Counter select |
| rd_data_o | output | 16 | Selected counter, registered |

## Verification
The assertions assume that every input is a known value at each clock edge once reset is released. They also assume that `clear_i`, `win_valid_i` and `count_en_i` may take any combination, including a clear in the same cycle as a window. The bench drives all inputs on the falling edge, so each value is settled before the rising edge. It deliberately combines clear with a valid window, and it runs read addresses past the last counter. The saturation run needs no special input: it holds the alternating pattern long enough for every boundary to reach the top count.

// File: rtl/leh_pkg.sv
package leh_pkg;
   // next value of a transition counter: saturating or wrapping increment
   function automatic logic [15:0] leh_step16(input logic [15:0] q, input bit sat);
      if (sat && (q == 16'hFFFF)) return q;
      return q + 16'd1;
   endfunction
endpackage

// File: rtl/leh_edge_detect.sv
module leh_edge_detect #(
   parameter int N_POS = 10
) (
   input  logic [N_POS-1:0] older_i,
   input  logic [N_POS-1:0] newer_i,
   output logic [N_POS-1:0] hit_o
);
   genvar k;
   generate
      for (k = 0; k < N_POS; k++) begin : g_bnd
         if (k < N_POS - 3) begin : g_inner
            assign hit_o[k] = older_i[k+2] ^ older_i[k+3];
         end else if (k == N_POS - 3) begin : g_wrap
            assign hit_o[k] = older_i[N_POS-1] ^ newer_i[0];
         end else if (k == N_POS - 2) begin : g_new12
            assign hit_o[k] = newer_i[1] ^ newer_i[2];
         end else begin : g_new01
            assign hit_o[k] = newer_i[0] ^ newer_i[1];
         end
      end
   endgenerate
endmodule

// File: rtl/leh_counter.sv
module leh_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] q_o
);
   logic [CNT_W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (q_o == {CNT_W{1'b1}}) ? q_o : q_o + 1'b1;
      end else begin : g_wrap
         assign nxt = q_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= '0;
      else if (clr_i) q_o <= '0;
      else if (inc_i) q_o <= nxt;
   end
endmodule

// File: rtl/leh_read_port.sv
module leh_read_port #(
   parameter int N_POS  = 10,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [N_POS*CNT_W-1:0] cnt_flat_i,
   output logic [CNT_W-1:0]       data_o
);
   logic [CNT_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < N_POS; i++) begin
         if (addr_i == ADDR_W'(i)) sel = cnt_flat_i[i*CNT_W +: CNT_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_o <= '0;
      else        data_o <= sel;
   end
endmodule

// File: rtl/lane_edge_hist.sv
module lane_edge_hist #(
   parameter int N_POS    = 10,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1,
   localparam int ADDR_W  = $clog2(N_POS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_POS-1:0]  win_i,
   input  logic              win_valid_i,
   input  logic              count_en_i,
   input  logic              clear_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [CNT_W-1:0]  rd_data_o
);
   generate
      if (N_POS < 4) begin : g_bad_pos
         $error("lane_edge_hist: N_POS must be at least 4");
      end
      if (CNT_W < 1) begin : g_bad_w
         $error("lane_edge_hist: CNT_W must be positive");
      end
   endgenerate

   logic [N_POS-1:0]       prev_win;
   logic                   prev_valid;
   logic [N_POS-1:0]       hit;
   logic                   bump;
   logic [N_POS*CNT_W-1:0] cnt_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_win   <= '0;
         prev_valid <= 1'b0;
      end else if (clear_i) begin
         prev_win   <= '0;
         prev_valid <= 1'b0;
      end else if (win_valid_i) begin
         prev_win   <= win_i;
         prev_valid <= 1'b1;
      end
   end

   leh_edge_detect #(.N_POS(N_POS)) u_edges (
      .older_i (prev_win),
      .newer_i (win_i),
      .hit_o   (hit)
   );

   assign bump = win_valid_i & count_en_i & prev_valid & ~clear_i;

   genvar k;
   generate
      for (k = 0; k < N_POS; k++) begin : g_cnt
         leh_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clear_i),
            .inc_i (bump & hit[k]),
            .q_o   (cnt_flat[k*CNT_W +: CNT_W])
         );
      end
   endgenerate

   leh_read_port #(.N_POS(N_POS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (rd_addr_i),
      .cnt_flat_i (cnt_flat),
      .data_o     (rd_data_o)
   );
endmodule

// File: rtl/leh_checker.sv
module leh_checker #(
   parameter int N_POS    = 10,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1,
   parameter int ADDR_W   = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   win_valid_i,
   input logic                   count_en_i,
   input logic                   clear_i,
   input logic [ADDR_W-1:0]      rd_addr_i,
   input logic [CNT_W-1:0]       rd_data_o,
   input logic [N_POS*CNT_W-1:0] cnt_flat,
   input logic                   prev_valid
);
   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_flat == '0) && !prev_valid);

   assert_paused_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !(win_valid_i && count_en_i)) |=> $stable(cnt_flat));

   assert_first_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && win_valid_i && !prev_valid) |=> $stable(cnt_flat) && prev_valid);

   assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr_i) >= N_POS) |=> rd_data_o == '0);

   genvar i;
   generate
      for (i = 0; i < N_POS; i++) begin : g_c
         assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !clear_i |=> (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W])) ||
                         (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1));
         if (SATURATE) begin : g_sat
            assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (!clear_i && cnt_flat[i*CNT_W +: CNT_W] == {CNT_W{1'b1}})
               |=> cnt_flat[i*CNT_W +: CNT_W] == {CNT_W{1'b1}});
         end
      end
   endgenerate
endmodule

bind lane_edge_hist leh_checker #(
   .N_POS(N_POS), .CNT_W(CNT_W), .SATURATE(SATURATE), .ADDR_W(ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .win_valid_i (win_valid_i),
   .count_en_i  (count_en_i),
   .clear_i     (clear_i),
   .rd_addr_i   (rd_addr_i),
   .rd_data_o   (rd_data_o),
   .cnt_flat    (cnt_flat),
   .prev_valid  (prev_valid)
);

// File: tb/tb_lane_edge_hist.sv
module tb_lane_edge_hist;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  win_i = '0;
   logic        win_valid_i = 1'b0;
   logic        count_en_i = 1'b0;
   logic        clear_i = 1'b0;
   logic [3:0]  rd_addr_i = '0;
   logic [15:0] rd_data_o;

   int checks = 0;
   int errors = 0;
   int exp_cnt [10];
   logic [9:0] m_prev = '0;
   bit m_pv = 0;

   always #5 clk = ~clk;

   lane_edge_hist dut (
      .clk(clk), .rst_n(rst_n), .win_i(win_i), .win_valid_i(win_valid_i),
      .count_en_i(count_en_i), .clear_i(clear_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o)
   );

   function automatic bit bnd(input logic [9:0] o, input logic [9:0] n, input int k);
      if (k <= 6) return o[k+2] ^ o[k+3];   // R1
      if (k == 7) return o[9] ^ n[0];       // R2
      if (k == 8) return n[1] ^ n[2];       // R3
      return n[0] ^ n[1];                   // R3
   endfunction

   task automatic send(input logic [9:0] w, input bit en);
      @(negedge clk);
      clear_i = 0; win_valid_i = 1; count_en_i = en; win_i = w;
      if (en && m_pv) begin
         for (int k = 0; k < 10; k++)
            if (bnd(m_prev, w, k) && exp_cnt[k] < 65535) exp_cnt[k]++;
      end
      m_prev = w; m_pv = 1;
   endtask

   task automatic do_clear(input logic [9:0] w);
      @(negedge clk);
      clear_i = 1; win_valid_i = 1; count_en_i = 1; win_i = w;   // R7 priority over window
      for (int k = 0; k < 10; k++) exp_cnt[k] = 0;
      m_pv = 0; m_prev = '0;
   endtask

   task automatic rd_check(input int a, input string ctx);
      int e;
      string req;
      @(negedge clk);
      clear_i = 0; win_valid_i = 0; count_en_i = 0; rd_addr_i = 4'(a);
      @(negedge clk);
      e = (a < 10) ? exp_cnt[a] : 0;
      if (a <= 6) req = "R1"; else if (a == 7) req = "R2";
      else if (a <= 9) req = "R3"; else req = "R8";
      checks++;
      if (rd_data_o !== 16'(e)) begin
         errors++;
         $display("FAIL %s/%s addr %0d actual %0d expected %0d", req, ctx, a, rd_data_o, e);
      end
   endtask

   task automatic check_all(input string ctx);
      for (int a = 0; a < 16; a++) rd_check(a, ctx);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 10; k++) exp_cnt[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      check_all("R9 reset");

      // R4: first window after reset only stored
      send(10'b1010101010, 1);
      check_all("R4 first window");

      // R1 R2 R3: sweep every window value, enabled
      for (int w = 0; w < 1024; w++) send(10'(w), 1);
      check_all("R1 sweep");

      // R5: paused windows still stored, counters fixed
      send(10'b0000000000, 0);
      send(10'b1111111111, 0);
      send(10'b1000000000, 0);
      check_all("R5 paused");
      send(10'b0000000110, 1);   // compares against paused window
      check_all("R5 history");

      // R7: clear with a coincident window, then first window not counted
      do_clear(10'b0101010101);
      check_all("R7 clear");
      send(10'b1010101010, 1);
      check_all("R7 stale dropped");
      send(10'b0110011001, 1);
      send(10'b1100110011, 1);
      check_all("R2 mixed");

      // R6: saturation with alternating windows
      do_clear(10'b0);
      for (int n = 0; n < 65540; n++) send(10'b1010101010, 1);
      check_all("R6 saturate");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule